// File: doc/BRIEF.md
# Programmable-Modulo Up/Down Loop Counter

This block is the loop-filter counter of an all-digital phase-locked loop. On every rising edge of its clock, while enabled, it steps a count up or down. The step direction comes from the phase detector's output. When the count wraps at the top while climbing, the block raises a one-cycle carry pulse. When it wraps below zero while descending, it raises a one-cycle borrow pulse. A downstream pulse add/delete stage uses these pulses to steer the output frequency.

The modulus is a power of two chosen at run time by a 4-bit code. A short modulus gives a wide capture range and a fast lock. A long modulus gives a narrow bandwidth and a slow lock. One code value stops the counter entirely. Because the code can change while the loop runs, the count is folded into the new range on the next clock, so a shrinking modulus never leaves stale high bits behind.

Top module: `dpll_loop_counter`

## Requirements
- R1: After reset both pulse outputs are low and the count is zero. From reset, code 1 counting up produces its first carry on the 8th enabled edge, and counting down produces a borrow on the first enabled edge.
- R2: Code 0 inhibits the counter: no carry or borrow is produced, and the count is held for later use.
- R3: A code n from 1 to 15 sets the modulus to 2^(n+2). Code 1 gives 8 and code 15 gives 131072, so a count of 131071 carries on the next up step.
- R4: Counting up from modulus-1 to 0 makes carry_pulse high for exactly one clock cycle. The pulse is high during the cycle that follows the wrapping edge.
- R5: Counting down from 0 to modulus-1 makes borrow_pulse high for exactly one clock cycle. The pulse is high during the cycle that follows the wrapping edge.
- R6: dn_sel low (0) counts up and dn_sel high (1) counts down. Both dn_sel and cnt_en are sampled on the rising clock edge.
- R7: While cnt_en is low the count is held (masked to the current width) and no pulse is produced.
- R8: On every clock with a nonzero code, count bits at or above the selected width are cleared. Lower bits are kept.
- R9: carry_pulse and borrow_pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally over two edges |
| cnt_en | input | 1 | Count enable, sampled on the rising edge |
| dn_sel | input | 1 | Direction: 0 up, 1 down |
| modulus_code | input | 4 | 0 inhibits; n selects modulus 2^(n+2) |
| carry_pulse | output | 1 | Registered one-cycle pulse on an upward wrap |
| borrow_pulse | output | 1 | Registered one-cycle pulse on a downward wrap |

## Verification
Every cycle, the assertions check the following:
- The two pulses never coincide, and each lasts exactly one cycle.
- No pulse follows a disabled or inhibited cycle.
- A carry never follows a down step, and a borrow never follows an up step.

Only the bench's scenarios can show the rest. These include the exact wrap point for each modulus, the full 17-bit width at code 15, and the folding of high bits when the code shrinks. A cycle-accurate reference model compares both pulses on every step of the directed and random sequences.

// File: rtl/loop_ctr_pkg.sv
package loop_ctr_pkg;

  // Default sizing: 4-bit code, shortest counter three stages.
  localparam int unsigned CODE_W_DEF     = 4;
  localparam int unsigned MIN_STAGES_DEF = 3;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef struct packed {
    logic carry;
    logic borrow;
  } wrap_t;

endpackage

// File: rtl/loop_ctr_rst_sync.sv
module loop_ctr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/loop_ctr_mask.sv
module loop_ctr_mask #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned MIN_STAGES = 3,
  parameter int unsigned CNT_W      = 17
) (
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);

  assign active = (code != '0);

  // Bit i belongs to the counter when i < code + MIN_STAGES - 1,
  // i.e. code >= i - MIN_STAGES + 2.
  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    localparam int TH = i - int'(MIN_STAGES) + 2;
    if (TH <= 1) begin : g_always
      assign mask[i] = active;
    end else begin : g_cmp
      localparam logic [CODE_W-1:0] TH_C = CODE_W'(TH);
      assign mask[i] = (code >= TH_C);
    end
  end

endmodule

// File: rtl/loop_ctr_core.sv
module loop_ctr_core
  import loop_ctr_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  dir_e             dir,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  output wrap_t            wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] folded;
  logic             cnt_ld;
  wrap_t            wrap_d;
  wrap_t            wrap_q;

  // Counter state only advances (or folds) when a modulus is selected.
  assign cnt_ld = active;
  assign folded = cnt_q & mask;

  always_comb begin
    cnt_d  = folded;
    wrap_d = '0;
    if (active && en) begin
      if (dir == DIR_UP) begin
        if (folded == mask) begin
          cnt_d        = '0;
          wrap_d.carry = 1'b1;
        end else begin
          cnt_d = folded + CNT_W'(1);
        end
      end else begin
        if (folded == '0) begin
          cnt_d         = mask;
          wrap_d.borrow = 1'b1;
        end else begin
          cnt_d = folded - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= '0;
    end else begin
      wrap_q <= wrap_d;
    end
  end

  assign wrap_o = wrap_q;

endmodule

// File: rtl/dpll_loop_counter.sv
module dpll_loop_counter
  import loop_ctr_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned MIN_STAGES  = MIN_STAGES_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              dn_sel,
  input  logic [CODE_W-1:0] modulus_code,
  output logic              carry_pulse,
  output logic              borrow_pulse
);

  localparam int unsigned CNT_W = MIN_STAGES + (2 ** CODE_W) - 2;

  logic             rst_sync_n;
  logic             active;
  logic [CNT_W-1:0] mask;
  wrap_t            wrap;

  loop_ctr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  loop_ctr_mask #(
    .CODE_W     (CODE_W),
    .MIN_STAGES (MIN_STAGES),
    .CNT_W      (CNT_W)
  ) i_mask (
    .code   (modulus_code),
    .active (active),
    .mask   (mask)
  );

  loop_ctr_core #(
    .CNT_W (CNT_W)
  ) i_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (cnt_en),
    .dir    (dir_e'(dn_sel)),
    .active (active),
    .mask   (mask),
    .wrap_o (wrap)
  );

  assign carry_pulse  = wrap.carry;
  assign borrow_pulse = wrap.borrow;

endmodule

// File: rtl/dpll_loop_counter_chk.sv
module dpll_loop_counter_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              dn_sel,
  input logic [CODE_W-1:0] modulus_code,
  input logic              carry_pulse,
  input logic              borrow_pulse
);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_pulse && borrow_pulse));

  assert_carry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_pulse |=> !carry_pulse);

  assert_borrow_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_pulse |=> !borrow_pulse);

  assert_inhibit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (modulus_code == '0) |=> (!carry_pulse && !borrow_pulse));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (!carry_pulse && !borrow_pulse));

  assert_down_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sel |=> !carry_pulse);

  assert_up_no_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_sel |=> !borrow_pulse);

endmodule

bind dpll_loop_counter dpll_loop_counter_chk #(
  .CODE_W (CODE_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en       (cnt_en),
  .dn_sel       (dn_sel),
  .modulus_code (modulus_code),
  .carry_pulse  (carry_pulse),
  .borrow_pulse (borrow_pulse)
);

// File: tb/test_dpll_loop_counter.sv
module test_dpll_loop_counter;

  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic       dn_sel;
  logic [3:0] modulus_code;
  logic       carry_pulse;
  logic       borrow_pulse;

  int unsigned n_cmp;
  int unsigned n_bad;
  bit          done;
  int unsigned m_cnt;
  logic        exp_c;
  logic        exp_b;

  dpll_loop_counter i_dpll_loop_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .dn_sel       (dn_sel),
    .modulus_code (modulus_code),
    .carry_pulse  (carry_pulse),
    .borrow_pulse (borrow_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int unsigned mod_mask(input logic [3:0] code);
    if (code == 4'd0) return 0;
    return (32'd1 << (int'(code) + 2)) - 1;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Reference model update for one clock edge.
  task automatic model(input logic e, input logic d, input logic [3:0] m);
    int unsigned mk;
    int unsigned eff;
    mk    = mod_mask(m);
    exp_c = 1'b0;
    exp_b = 1'b0;
    if (m != 4'd0) begin
      eff = m_cnt & mk;
      if (!e) begin
        m_cnt = eff;
      end else if (!d) begin
        if (eff == mk) begin m_cnt = 0; exp_c = 1'b1; end
        else m_cnt = eff + 1;
      end else begin
        if (eff == 0) begin m_cnt = mk; exp_b = 1'b1; end
        else m_cnt = eff - 1;
      end
    end
  endtask

  task automatic step(input logic e, input logic d, input logic [3:0] m, input string tag);
    cnt_en       = e;
    dn_sel       = d;
    modulus_code = m;
    @(posedge clk);
    model(e, d, m);
    @(negedge clk);
    chk(tag, "carry", carry_pulse, exp_c);
    chk(tag, "borrow", borrow_pulse, exp_b);
  endtask

  task automatic do_reset();
    rst_n        = 1'b0;
    cnt_en       = 1'b0;
    dn_sel       = 1'b0;
    modulus_code = 4'd1;
    m_cnt        = 0;
    repeat (3) @(negedge clk);
    chk("R1", "carry in reset", carry_pulse, 1'b0);
    chk("R1", "borrow in reset", borrow_pulse, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 4'd1, "R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r;
    int unsigned run;
    logic        d;
    logic [3:0]  m;
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    r = $urandom(32'd1357);

    // R1: first carry from reset at code 1 lands on the 8th enabled edge.
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      step(1'b1, 1'b0, 4'd1, "R1");
      chk("R1", "carry at edge index", carry_pulse, (k == 8) ? 1'b1 : 1'b0);
    end
    // R4: pulse is gone on the next edge.
    step(1'b1, 1'b0, 4'd1, "R4");
    chk("R4", "carry width", carry_pulse, 1'b0);

    // R1/R5: down from reset borrows at once.
    do_reset();
    step(1'b1, 1'b1, 4'd2, "R5");
    chk("R5", "borrow from zero", borrow_pulse, 1'b1);
    step(1'b1, 1'b1, 4'd2, "R5");
    chk("R5", "borrow width", borrow_pulse, 1'b0);

    // R3: code 15 is 17 bits wide; from 131071 an up step carries.
    do_reset();
    step(1'b1, 1'b1, 4'd15, "R3");
    chk("R3", "borrow to 131071", borrow_pulse, 1'b1);
    step(1'b1, 1'b0, 4'd15, "R3");
    chk("R3", "carry from 131071", carry_pulse, 1'b1);

    // R3: code 3 period of 32 up steps.
    do_reset();
    for (int k = 1; k <= 64; k++) begin
      step(1'b1, 1'b0, 4'd3, "R3");
      chk("R3", "code3 period", carry_pulse, (k % 32 == 0) ? 1'b1 : 1'b0);
    end

    // R8: shrink code from 15 to 1, high bits drop, count becomes 7.
    do_reset();
    step(1'b1, 1'b1, 4'd15, "R8");
    step(1'b0, 1'b0, 4'd1, "R8");
    step(1'b1, 1'b0, 4'd1, "R8");
    chk("R8", "carry after fold", carry_pulse, 1'b1);

    // R2: code 0 inhibits and holds; R7: enable low holds.
    do_reset();
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 4'd2, "R2");
    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      step(r[0], r[1], 4'd0, "R2");
    end
    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      step(1'b0, r[1], 4'd2, "R7");
    end
    // Count was 5 of 16 before both phases: 11 more up steps reach a carry.
    for (int k = 1; k <= 11; k++) begin
      step(1'b1, 1'b0, 4'd2, "R7");
      chk("R7", "held count resumes", carry_pulse, (k == 11) ? 1'b1 : 1'b0);
    end

    // R4/R5/R6/R9: random runs with changing direction and code.
    do_reset();
    for (int k = 0; k < 300; k++) begin
      r   = $urandom;
      run = 1 + (r % 40);
      d   = r[8];
      m   = (r[12:10] == 3'd0) ? 4'd0 : 4'(1 + (r[17:16] % 3));
      for (int j = 0; j < int'(run); j++) begin
        r = $urandom;
        step((r[3:0] != 4'd0), d, m, "R6");
        chk("R9", "no overlap", carry_pulse & borrow_pulse, 1'b0);
      end
    end

    finish_run();
  end

endmodule